// File: doc/BRIEF.md
# Serial Byte Receiver with Bus Read Port

This block receives asynchronous serial frames and offers each byte to software through a small bus slave that only reads. A frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. The line idles high. Bit timing comes from a separate baud clock input. The block brings that clock into the system clock domain, divides it by the divisor input, and then by a fixed factor of four. Each bit period is therefore four sample ticks. For example, a 500 kHz baud clock with a divisor of one gives 125 kbit/s.

The serial input passes through two flip-flops. A low level seen on a tick only counts as a start bit if the line is still low two ticks later, at the middle of the bit. Each data bit is then sampled four ticks after the one before, which puts the sample near the middle of the bit. The stop bit is sampled the same way. The byte is stored even when the stop bit is wrong. A new frame can start straight after the stop bit, with no idle time between frames.

The byte leaves the block through the bus and has no valid/ready handshake. The receiver cannot be held back. When software has not read a byte before the next one finishes, the new byte overwrites it and the overrun flag is set. The interrupt output follows the data-ready flag.

Top module: `uart_rx_wb`

## Requirements
- R1: After a synchronous reset, the interrupt is low and a status read returns 0.
- R2: Acknowledge rises in the clock after the bus first sees strobe, lasts one clock, and is high only while strobe is high.
- R3: Address 0 reads the received byte. Address 1 reads status: bit 0 is data-ready, bit 1 is overrun, bit 2 is framing error, and the other bits are 0. Addresses 2 and 3 read 0. A write is acknowledged and changes nothing.
- R4: One bit period is 4 × divisor baud-clock periods. A divisor of 0 acts as 1.
- R5: A frame with a low start bit, eight data bits sent least significant bit first, and a high stop bit delivers the byte correctly for any data value.
- R6: Frames with no idle gap between them are all received correctly.
- R7: A low pulse on the line that is shorter than half a bit is not taken as a start bit, and no byte results from it.
- R8: A finished byte sets data-ready. The interrupt equals data-ready. Reading address 0 clears data-ready.
- R9: A byte that finishes while data-ready is still set sets overrun. Reading address 1 clears overrun.
- R10: A stop bit sampled low sets the framing flag, and the byte is still stored. The framing flag describes the most recent byte.
- R11: When a data read and a byte arrival fall in the same clock, the read returns the old byte, data-ready stays set and overrun is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and bus clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Bus write enable (writes have no effect) |
| wb_adr | input | 2 | Register address |
| wb_dat_i | input | 8 | Bus write data (not used) |
| wb_dat_o | output | 8 | Bus read data, valid while acknowledge is high |
| wb_ack | output | 1 | Bus acknowledge |
| baud_clk | input | 1 | Baud reference clock, slower than clk/2 |
| baud_div | input | 8 | Baud divisor |
| rxd | input | 1 | Serial input line |
| rx_irq | output | 1 | Byte-available interrupt |

## Verification
A bus read of the data register and the completion of a new byte can land in the same clock. Both of them change data-ready and overrun. The bench leaves one byte unread and sends a second frame. It starts a data read at offsets that step in 5 ns increments across the whole stop bit, so one offset meets the completion cycle exactly. The byte the read returns shows which event came first. If the old byte came back, data-ready must still be set and overrun must be clear. If the new byte came back, data-ready must be clear and overrun must be set. Any other mix counts as a failure.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  localparam int STS_READY = 0;
  localparam int STS_OVR   = 1;
  localparam int STS_FERR  = 2;

  localparam logic [1:0] ADR_DATA   = 2'd0;
  localparam logic [1:0] ADR_STATUS = 2'd1;
endpackage

// File: rtl/rx_sync_chain.sv
module rx_sync_chain #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RESET_VAL;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             baud_clk,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic             bclk_s;
  logic             bclk_prev;
  logic             bclk_rise;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  rx_sync_chain #(.STAGES(2), .RESET_VAL(1'b0)) u_bsync (
    .clk (clk),
    .rst (rst),
    .din (baud_clk),
    .dout(bclk_s)
  );

  always_ff @(posedge clk) begin
    if (rst) bclk_prev <= 1'b0;
    else     bclk_prev <= bclk_s;
  end

  assign bclk_rise = bclk_s & ~bclk_prev;
  assign limit     = (div == '0) ? DIV_W'(1) : div;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (bclk_rise) begin
        if (cnt >= limit - DIV_W'(1)) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rx_deser.sv
module rx_deser
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 rxd,
  output logic                 done,
  output logic [DATA_BITS-1:0] data,
  output logic                 ferr
);
  localparam int CW = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam int BW = (DATA_BITS > 2) ? $clog2(DATA_BITS) : 1;
  localparam logic [CW-1:0] LAST_TICK = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] HALF_TICK = CW'(OVERSAMPLE / 2 - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_BITS - 1);

  rx_state_e            state;
  logic [CW-1:0]        tcnt;
  logic [BW-1:0]        bidx;
  logic [DATA_BITS-1:0] shreg;
  logic                 rx_s;

  rx_sync_chain #(.STAGES(2), .RESET_VAL(1'b1)) u_rsync (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(rx_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      tcnt  <= '0;
      bidx  <= '0;
      shreg <= '0;
      done  <= 1'b0;
      data  <= '0;
      ferr  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (state)
          RX_IDLE: begin
            if (!rx_s) begin
              state <= RX_START;
              tcnt  <= '0;
            end
          end
          RX_START: begin
            if (tcnt == HALF_TICK) begin
              tcnt <= '0;
              bidx <= '0;
              state <= rx_s ? RX_IDLE : RX_DATA;
            end else begin
              tcnt <= tcnt + CW'(1);
            end
          end
          RX_DATA: begin
            if (tcnt == LAST_TICK) begin
              tcnt  <= '0;
              shreg <= {rx_s, shreg[DATA_BITS-1:1]};
              if (bidx == LAST_BIT) state <= RX_STOP;
              else                  bidx  <= bidx + BW'(1);
            end else begin
              tcnt <= tcnt + CW'(1);
            end
          end
          RX_STOP: begin
            if (tcnt == LAST_TICK) begin
              tcnt  <= '0;
              done  <= 1'b1;
              data  <= shreg;
              ferr  <= ~rx_s;
              state <= RX_IDLE;
            end else begin
              tcnt <= tcnt + CW'(1);
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_wb_regs.sv
module rx_wb_regs
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic              we,
  input  logic [1:0]        adr,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_ferr,
  output logic [DATA_W-1:0] dat_o,
  output logic              ack,
  output logic              irq,
  output logic              sts_ovr
);
  logic              ack_q;
  logic              rd_fire;
  logic              rd_data;
  logic              rd_status;
  logic              ready;
  logic              ferr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] status;
  logic [DATA_W-1:0] rdata;

  assign rd_fire   = stb & ~ack_q & ~we;
  assign rd_data   = rd_fire && (adr == ADR_DATA);
  assign rd_status = rd_fire && (adr == ADR_STATUS);

  always_comb begin
    status            = '0;
    status[STS_READY] = ready;
    status[STS_OVR]   = sts_ovr;
    status[STS_FERR]  = ferr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      rdata   <= '0;
      ready   <= 1'b0;
      sts_ovr <= 1'b0;
      ferr_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      ack_q <= stb & ~ack_q;
      if (rd_fire) begin
        unique case (adr)
          ADR_DATA:   rdata <= data_q;
          ADR_STATUS: rdata <= status;
          default:    rdata <= '0;
        endcase
      end
      if (rx_done)      ready <= 1'b1;
      else if (rd_data) ready <= 1'b0;
      if (rx_done && ready && !rd_data) sts_ovr <= 1'b1;
      else if (rd_status)               sts_ovr <= 1'b0;
      if (rx_done) begin
        ferr_q <= rx_ferr;
        data_q <= rx_data;
      end
    end
  end

  assign ack   = ack_q & stb;
  assign dat_o = rdata;
  assign irq   = ready;
endmodule

// File: rtl/uart_rx_wb.sv
module uart_rx_wb #(
  parameter int DATA_W     = 8,
  parameter int DIV_W      = 8,
  parameter int OVERSAMPLE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_stb,
  input  logic              wb_we,
  input  logic [1:0]        wb_adr,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic              wb_ack,
  input  logic              baud_clk,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              rxd,
  output logic              rx_irq
);
  logic              tick;
  logic              rx_done;
  logic [DATA_W-1:0] rx_data;
  logic              rx_ferr;
  logic              sts_ovr;
  logic              wdat_unused;

  assign wdat_unused = ^wb_dat_i;

  rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .baud_clk(baud_clk),
    .div     (baud_div),
    .tick    (tick)
  );

  rx_deser #(.DATA_BITS(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_deser (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .rxd (rxd),
    .done(rx_done),
    .data(rx_data),
    .ferr(rx_ferr)
  );

  rx_wb_regs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .stb    (wb_stb),
    .we     (wb_we),
    .adr    (wb_adr),
    .rx_done(rx_done),
    .rx_data(rx_data),
    .rx_ferr(rx_ferr),
    .dat_o  (wb_dat_o),
    .ack    (wb_ack),
    .irq    (rx_irq),
    .sts_ovr(sts_ovr)
  );
endmodule

// File: rtl/uart_rx_wb_chk.sv
module uart_rx_wb_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wb_stb,
  input logic              wb_we,
  input logic [1:0]        wb_adr,
  input logic              wb_ack,
  input logic [DATA_W-1:0] wb_dat_o,
  input logic              rx_irq,
  input logic              rx_done,
  input logic              sts_ovr
);
  logic rd_data_req;
  assign rd_data_req = wb_stb && !wb_ack && !wb_we && (wb_adr == 2'd0);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !rx_irq);

  p_ack_after_stb_r2: assert property (@(posedge clk) disable iff (rst)
    wb_ack |-> $past(wb_stb));

  p_ack_single_r2: assert property (@(posedge clk) disable iff (rst)
    wb_ack |=> !wb_ack);

  p_irq_in_status_r8: assert property (@(posedge clk) disable iff (rst)
    (wb_ack && !wb_we && $past(wb_adr) == 2'd1 && !$past(rst))
      |-> (wb_dat_o[0] == $past(rx_irq)));

  p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_data_req && !rx_done) |=> !rx_irq);

  p_overrun_set_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_irq && !rd_data_req) |=> sts_ovr);

  p_arrival_wins_r11: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> rx_irq);
endmodule

bind uart_rx_wb uart_rx_wb_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wb_stb  (wb_stb),
  .wb_we   (wb_we),
  .wb_adr  (wb_adr),
  .wb_ack  (wb_ack),
  .wb_dat_o(wb_dat_o),
  .rx_irq  (rx_irq),
  .rx_done (rx_done),
  .sts_ovr (sts_ovr)
);

// File: tb/uart_rx_wb_bench.sv
`timescale 1ns/1ps
module uart_rx_wb_bench;
  localparam real BIT1 = 160.0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wb_stb = 1'b0;
  logic       wb_we = 1'b0;
  logic [1:0] wb_adr = 2'd0;
  logic [7:0] wb_dat_i = 8'd0;
  logic [7:0] wb_dat_o;
  logic       wb_ack;
  logic       baud_clk = 1'b0;
  logic [7:0] baud_div = 8'd1;
  logic       rxd = 1'b1;
  logic       rx_irq;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;
  always #20 baud_clk = ~baud_clk;

  uart_rx_wb u_uart_rx_wb (
    .clk(clk), .rst(rst), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o), .wb_ack(wb_ack),
    .baud_clk(baud_clk), .baud_div(baud_div), .rxd(rxd), .rx_irq(rx_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop, input real bt);
    rxd = 1'b0; #(bt);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; #(bt); end
    rxd = stop; #(bt);
    rxd = 1'b1;
  endtask

  task automatic wb_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); wb_adr = a; wb_we = 1'b0; wb_stb = 1'b1;
    @(negedge clk); d = wb_dat_o; wb_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic wb_write(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); wb_adr = a; wb_we = 1'b1; wb_dat_i = v; wb_stb = 1'b1;
    @(negedge clk); wb_stb = 1'b0; wb_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain();
    logic [7:0] d;
    wb_read(2'd0, d);
    wb_read(2'd1, d);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq after reset", rx_irq, 0);
    wb_read(2'd1, d);
    check("R1 status after reset", d, 8'h00);
  endtask

  task automatic t_ack();
    @(negedge clk); wb_adr = 2'd1; wb_stb = 1'b1;
    check("R2 ack not in strobe cycle", wb_ack, 0);
    @(negedge clk); check("R2 ack next cycle", wb_ack, 1);
    @(negedge clk); check("R2 ack one cycle only", wb_ack, 0);
    wb_stb = 1'b0;
    @(negedge clk); wb_stb = 1'b1;
    @(posedge clk); #1 wb_stb = 1'b0;
    #0.5 check("R2 ack gated by strobe", wb_ack, 0);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_patterns();
    logic [7:0] pats [6] = '{8'h40, 8'hA5, 8'h01, 8'h80, 8'h00, 8'hFF};
    logic [7:0] d;
    foreach (pats[i]) begin
      send_frame(pats[i], 1'b1, BIT1);
      #(BIT1);
      check("R8 irq on byte", rx_irq, 1);
      wb_read(2'd1, d);
      check("R3 status ready only", d, 8'h01);
      wb_read(2'd0, d);
      check("R5 data LSB first", d, pats[i]);
      check("R8 irq cleared by data read", rx_irq, 0);
    end
  endtask

  task automatic t_map();
    logic [7:0] d;
    send_frame(8'h69, 1'b1, BIT1);
    #(BIT1);
    wb_write(2'd0, 8'hFF);
    wb_write(2'd1, 8'hFF);
    wb_read(2'd2, d); check("R3 addr 2 reads zero", d, 0);
    wb_read(2'd3, d); check("R3 addr 3 reads zero", d, 0);
    wb_read(2'd1, d); check("R3 write leaves status", d, 8'h01);
    wb_read(2'd0, d); check("R3 write leaves data", d, 8'h69);
  endtask

  task automatic t_divisor();
    logic [7:0] d;
    baud_div = 8'd2;
    send_frame(8'h96, 1'b1, 2.0 * BIT1);
    #(2.0 * BIT1);
    wb_read(2'd0, d); check("R4 divisor 2 rate", d, 8'h96);
    baud_div = 8'd0;
    send_frame(8'h3B, 1'b1, BIT1);
    #(BIT1);
    wb_read(2'd0, d); check("R4 divisor 0 acts as 1", d, 8'h3B);
    baud_div = 8'd1;
    drain();
  endtask

  task automatic t_back_to_back();
    logic [7:0] d1, d2, s;
    fork
      begin send_frame(8'h3C, 1'b1, BIT1); send_frame(8'hC3, 1'b1, BIT1); end
      begin #(10.3 * BIT1); wb_read(2'd0, d1); end
    join
    #(BIT1);
    wb_read(2'd1, s);
    wb_read(2'd0, d2);
    check("R6 first of pair", d1, 8'h3C);
    check("R6 second of pair", d2, 8'hC3);
    check("R6 no overrun on pair", s, 8'h01);
  endtask

  task automatic t_glitch();
    logic [7:0] d;
    rxd = 1'b0; #45; rxd = 1'b1;
    #(12.0 * BIT1);
    check("R7 glitch gives no byte", rx_irq, 0);
    wb_read(2'd1, d);
    check("R7 status after glitch", d, 8'h00);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    send_frame(8'h11, 1'b1, BIT1);
    send_frame(8'h22, 1'b1, BIT1);
    #(BIT1);
    wb_read(2'd1, d); check("R9 overrun set", d, 8'h03);
    wb_read(2'd1, d); check("R9 overrun cleared by status read", d, 8'h01);
    wb_read(2'd0, d); check("R9 newest byte kept", d, 8'h22);
  endtask

  task automatic t_framing();
    logic [7:0] d;
    send_frame(8'h5A, 1'b0, BIT1);
    #(3.0 * BIT1);
    wb_read(2'd1, d); check("R10 framing flag", d, 8'h05);
    wb_read(2'd0, d); check("R10 byte kept on framing error", d, 8'h5A);
    send_frame(8'hA6, 1'b1, BIT1);
    #(BIT1);
    wb_read(2'd1, d); check("R10 framing follows last byte", d, 8'h01);
    drain();
  endtask

  task automatic t_collision();
    logic [7:0] r, s, d;
    for (int off = 0; off <= 32; off++) begin
      drain();
      send_frame(8'hA1, 1'b1, BIT1);
      #(BIT1);
      wb_read(2'd1, s);
      fork
        send_frame(8'h5E, 1'b1, BIT1);
        begin #(9.0 * BIT1 + 5.0 * off); wb_read(2'd0, r); end
      join
      #(BIT1);
      wb_read(2'd1, s);
      if (r == 8'hA1) begin
        check("R11 old byte read keeps ready, no overrun", s, 8'h01);
        wb_read(2'd0, d);
        check("R11 new byte pending", d, 8'h5E);
      end else begin
        check("R11 late read returns new byte", r, 8'h5E);
        check("R11 late read leaves overrun only", s, 8'h02);
      end
    end
  endtask

  initial begin
    #(1_000_000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_ack();
    t_patterns();
    t_map();
    t_divisor();
    t_back_to_back();
    t_glitch();
    t_overrun();
    t_framing();
    t_collision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule